// File: doc/BRIEF.md
# Backplane Bus Arbiter with Local Priority

This block decides which master owns a shared backplane bus. Several external masters post requests on a request vector and are served in turn, in rotating order. One local processor sits ahead of all of them: whenever it asks for the bus it wins the next arbitration, as if it were wired first in the grant chain at a request level the external masters share. A local grant does not disturb the rotation. When the local processor finishes, the external masters resume exactly where the rotation had paused.

Ownership follows a simple handshake. The arbiter issues a grant only while the bus-busy line is low and no master holds a grant. The owner keeps the grant as long as it keeps requesting or holds bus-busy. The grant drops in the cycle after both are low. A transfer timer watches the transfer strobe. If no acknowledge arrives within a programmable number of cycles (about 12 microseconds at the default), it raises a bus error. The same error output also answers an external master that targets local memory while the subsystem-fail condition is still held after reset.

Top module: `bkpl_arbiter`

## Requirements
- R1: During and right after reset, no grant is active and the bus-error output is low.
- R2: When the local request is high at an arbitration edge, the local master is granted, whatever the external requests are.
- R3: External requests are served by rotation. The search starts at a pointer that is 0 after reset, and the first requesting index at or after it wins, wrapping from N_EXT-1 to 0. After an external grant, the pointer moves to the index just past the winner.
- R4: A local grant leaves the rotation pointer unchanged, so the next external grant continues from the prior position.
- R5: A new grant is issued one clock edge after an edge at which no grant is held, bus_busy is low and some request is high. No grant is issued while bus_busy is high.
- R6: A grant stays asserted while its owner requests or bus_busy is high. It drops at the first edge where both are low.
- R7: At most one of loc_gnt and ext_gnt[N_EXT-1:0] is high in any cycle, and a grant only rises for a master that was requesting.
- R8: bus_err rises at the TIMEOUT_CYC-th consecutive edge at which xfer_strobe is high and xfer_ack is low, and not earlier.
- R9: An edge with xfer_ack high restarts the timeout count from zero.
- R10: When xfer_strobe, mem_sel and fail_hold are all high while an external master holds the grant, bus_err is high after the next edge. A local owner is never answered this way.
- R11: bus_err stays high while xfer_strobe stays high, and is low after any edge at which xfer_strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_req | input | 1 | Local master bus request |
| ext_req | input | N_EXT | External master bus requests, one bit per master |
| bus_busy | input | 1 | Bus held by its current owner |
| xfer_strobe | input | 1 | Transfer in progress on the bus |
| xfer_ack | input | 1 | Slave acknowledge of the transfer |
| mem_sel | input | 1 | Current transfer addresses local memory |
| fail_hold | input | 1 | Subsystem-fail condition still asserted |
| loc_gnt | output | 1 | Grant to the local master |
| ext_gnt | output | N_EXT | Grants to external masters, one-hot or zero |
| bus_err | output | 1 | Bus error: timeout or refused local-memory access |

## Verification
The hardest state to reach from the ports is a wrapped rotation pointer that has been held across a local grant. Reaching it takes a specific sequence of grants and releases, and random traffic seldom lines these up before the next external win hides the effect. Directed sequences therefore walk the pointer to the top index, wrap it to zero, then insert a local grant and check which external master wins next. The full timeout window and its restart by an acknowledge are also rare under random traffic, so they are driven on purpose to the exact edge.

// File: rtl/bkpl_arb_pkg.sv
package bkpl_arb_pkg;

    // Who currently holds the bus
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_LOC  = 2'd1,
        OWN_EXT  = 2'd2
    } owner_e;

    // Pointer width for a given master count (at least one bit)
    function automatic int ptr_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Counter width able to hold the value lim
    function automatic int cnt_width(input int lim);
        return $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/bkpl_rr_pick.sv
module bkpl_rr_pick #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] start,
    output logic          hit,
    output logic [PW-1:0] win
);
    // Scan from start upward with wrap; the nearest requester wins.
    always_comb begin
        hit = 1'b0;
        win = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int unsigned s;
            s = int'(start) + k;
            if (s >= N) s = s - N;
            if (req[s]) begin
                hit = 1'b1;
                win = PW'(s);
            end
        end
    end
endmodule

// File: rtl/bkpl_grant_ctl.sv
module bkpl_grant_ctl
    import bkpl_arb_pkg::*;
#(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          loc_req,
    input  logic [N-1:0]  ext_req,
    input  logic          bus_busy,
    input  logic          pick_hit,
    input  logic [PW-1:0] pick_win,
    output owner_e        own_kind,
    output logic [PW-1:0] own_idx,
    output logic [PW-1:0] rr_ptr
);
    localparam logic [PW-1:0] LAST = PW'(N - 1);

    logic owner_wants;

    always_comb begin
        unique case (own_kind)
            OWN_LOC: owner_wants = loc_req;
            OWN_EXT: owner_wants = ext_req[own_idx];
            default: owner_wants = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_kind <= OWN_NONE;
            own_idx  <= '0;
            rr_ptr   <= '0;
        end else if (own_kind == OWN_NONE) begin
            if (!bus_busy) begin
                if (loc_req) begin
                    own_kind <= OWN_LOC;
                end else if (pick_hit) begin
                    own_kind <= OWN_EXT;
                    own_idx  <= pick_win;
                    rr_ptr   <= (pick_win == LAST) ? '0 : pick_win + 1'b1;
                end
            end
        end else if (!owner_wants && !bus_busy) begin
            own_kind <= OWN_NONE;
        end
    end
endmodule

// File: rtl/bkpl_bus_timer.sv
module bkpl_bus_timer #(
    parameter int LIMIT = 1500,
    parameter int CW    = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic ack,
    input  logic ext_owner,
    input  logic mem_sel,
    input  logic fail_hold,
    output logic err
);
    logic [CW-1:0] cnt;
    logic          tmo_hit;
    logic          fail_hit;

    assign tmo_hit  = strobe && !ack && (cnt == CW'(LIMIT - 1));
    assign fail_hit = strobe && mem_sel && fail_hold && ext_owner;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            err <= 1'b0;
        end else begin
            if (!strobe || ack)
                cnt <= '0;
            else if (cnt != CW'(LIMIT))
                cnt <= cnt + 1'b1;
            err <= strobe && (err || tmo_hit || fail_hit);
        end
    end
endmodule

// File: rtl/bkpl_arbiter.sv
module bkpl_arbiter
    import bkpl_arb_pkg::*;
#(
    parameter int N_EXT       = 4,
    parameter int TIMEOUT_CYC = 1500
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             loc_req,
    input  logic [N_EXT-1:0] ext_req,
    input  logic             bus_busy,
    input  logic             xfer_strobe,
    input  logic             xfer_ack,
    input  logic             mem_sel,
    input  logic             fail_hold,
    output logic             loc_gnt,
    output logic [N_EXT-1:0] ext_gnt,
    output logic             bus_err
);
    localparam int PW = ptr_width(N_EXT);
    localparam int CW = cnt_width(TIMEOUT_CYC);

    owner_e          own_kind;
    logic [PW-1:0]   own_idx;
    logic [PW-1:0]   rr_ptr;
    logic            pick_hit;
    logic [PW-1:0]   pick_win;

    bkpl_rr_pick #(.N(N_EXT), .PW(PW)) pick_i (
        .req   (ext_req),
        .start (rr_ptr),
        .hit   (pick_hit),
        .win   (pick_win)
    );

    bkpl_grant_ctl #(.N(N_EXT), .PW(PW)) gctl_i (
        .clk      (clk),
        .rst      (rst),
        .loc_req  (loc_req),
        .ext_req  (ext_req),
        .bus_busy (bus_busy),
        .pick_hit (pick_hit),
        .pick_win (pick_win),
        .own_kind (own_kind),
        .own_idx  (own_idx),
        .rr_ptr   (rr_ptr)
    );

    bkpl_bus_timer #(.LIMIT(TIMEOUT_CYC), .CW(CW)) tmr_i (
        .clk       (clk),
        .rst       (rst),
        .strobe    (xfer_strobe),
        .ack       (xfer_ack),
        .ext_owner (own_kind == OWN_EXT),
        .mem_sel   (mem_sel),
        .fail_hold (fail_hold),
        .err       (bus_err)
    );

    assign loc_gnt = (own_kind == OWN_LOC);

    for (genvar g = 0; g < N_EXT; g++) begin : g_gnt
        assign ext_gnt[g] = (own_kind == OWN_EXT) && (own_idx == PW'(g));
    end
endmodule

// File: rtl/bkpl_arbiter_chk.sv
module bkpl_arbiter_chk #(
    parameter int N_EXT = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             loc_req,
    input logic [N_EXT-1:0] ext_req,
    input logic             bus_busy,
    input logic             xfer_strobe,
    input logic             xfer_ack,
    input logic             mem_sel,
    input logic             fail_hold,
    input logic             loc_gnt,
    input logic [N_EXT-1:0] ext_gnt,
    input logic             bus_err
);
    assert_single_grant_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({loc_gnt, ext_gnt}));

    assert_loc_needs_req_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(loc_gnt) |-> $past(loc_req));

    assert_loc_idle_bus_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(loc_gnt) |-> !$past(bus_busy));

    assert_loc_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (loc_gnt && bus_busy) |=> loc_gnt);

    for (genvar i = 0; i < N_EXT; i++) begin : g_ext
        assert_ext_needs_req_R7: assert property (@(posedge clk) disable iff (rst)
            $rose(ext_gnt[i]) |-> $past(ext_req[i]));

        assert_local_first_R2: assert property (@(posedge clk) disable iff (rst)
            $rose(ext_gnt[i]) |-> !$past(loc_req));

        assert_ext_idle_bus_R5: assert property (@(posedge clk) disable iff (rst)
            $rose(ext_gnt[i]) |-> !$past(bus_busy));

        assert_ext_hold_R6: assert property (@(posedge clk) disable iff (rst)
            (ext_gnt[i] && bus_busy) |=> ext_gnt[i]);
    end

    assert_err_needs_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        !xfer_strobe |=> !bus_err);

    assert_fail_refuse_R10: assert property (@(posedge clk) disable iff (rst)
        (xfer_strobe && mem_sel && fail_hold && (|ext_gnt)) |=> bus_err);

    assert_ack_no_err_R9: assert property (@(posedge clk) disable iff (rst)
        (xfer_strobe && xfer_ack && !bus_err && !fail_hold) |=> !bus_err);
endmodule

bind bkpl_arbiter bkpl_arbiter_chk #(.N_EXT(N_EXT)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .loc_req     (loc_req),
    .ext_req     (ext_req),
    .bus_busy    (bus_busy),
    .xfer_strobe (xfer_strobe),
    .xfer_ack    (xfer_ack),
    .mem_sel     (mem_sel),
    .fail_hold   (fail_hold),
    .loc_gnt     (loc_gnt),
    .ext_gnt     (ext_gnt),
    .bus_err     (bus_err)
);

// File: tb/bkpl_arbiter_tb_top.sv
module bkpl_arbiter_tb_top;
    localparam int N   = 4;
    localparam int LIM = 1500;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         loc_req = 1'b0;
    logic [N-1:0] ext_req = '0;
    logic         bus_busy = 1'b0;
    logic         xfer_strobe = 1'b0;
    logic         xfer_ack = 1'b0;
    logic         mem_sel = 1'b0;
    logic         fail_hold = 1'b0;
    logic         loc_gnt;
    logic [N-1:0] ext_gnt;
    logic         bus_err;

    int n_vec  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;
    string tag = "R1";

    // bench model state
    bit m_loc = 1'b0;
    int m_ext = -1;
    int m_ptr = 0;
    int m_cnt = 0;
    bit m_err = 1'b0;

    always #4 clk = ~clk;

    bkpl_arbiter #(.N_EXT(N), .TIMEOUT_CYC(LIM)) dut_i (
        .clk (clk), .rst (rst), .loc_req (loc_req), .ext_req (ext_req),
        .bus_busy (bus_busy), .xfer_strobe (xfer_strobe), .xfer_ack (xfer_ack),
        .mem_sel (mem_sel), .fail_hold (fail_hold), .loc_gnt (loc_gnt),
        .ext_gnt (ext_gnt), .bus_err (bus_err)
    );

    task automatic chk(input bit ok, input string t, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
        end
    endtask

    function automatic int exp_ext();
        return (m_ext >= 0) ? (1 << m_ext) : 0;
    endfunction

    // next model state from the inputs present at the coming edge
    task automatic model_step();
        bit t_hit, f_hit, own_req;
        if (rst) begin
            m_loc = 0; m_ext = -1; m_ptr = 0; m_cnt = 0; m_err = 0;
            return;
        end
        t_hit = xfer_strobe && !xfer_ack && (m_cnt == LIM - 1);
        f_hit = xfer_strobe && mem_sel && fail_hold && (m_ext >= 0);
        m_err = xfer_strobe && (m_err || t_hit || f_hit);
        if (!xfer_strobe || xfer_ack) m_cnt = 0;
        else if (m_cnt < LIM) m_cnt++;
        if (!m_loc && m_ext < 0) begin
            if (!bus_busy) begin
                if (loc_req) m_loc = 1;
                else begin
                    for (int k = 0; k < N; k++) begin
                        int s;
                        s = (m_ptr + k) % N;
                        if (m_ext < 0 && ext_req[s]) m_ext = s;
                    end
                    if (m_ext >= 0) m_ptr = (m_ext + 1) % N;
                end
            end
        end else begin
            own_req = m_loc ? loc_req : ext_req[m_ext];
            if (!own_req && !bus_busy) begin
                m_loc = 0; m_ext = -1;
            end
        end
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(ext_gnt == N'(exp_ext()), tag, "ext_gnt", int'(ext_gnt), exp_ext());
        chk(loc_gnt == m_loc, tag, "loc_gnt", int'(loc_gnt), int'(m_loc));
        chk(bus_err == m_err, tag, "bus_err", int'(bus_err), int'(m_err));
    endtask

    task automatic cycn(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        tag = "R1";
        cycn(3);
        chk(ext_gnt == 0 && !loc_gnt && !bus_err, "R1", "reset outputs",
            int'({loc_gnt, ext_gnt, bus_err}), 0);
        rst = 1'b0;
        cyc();

        // rotation and wrap
        tag = "R3";
        ext_req = 4'b1010; cyc();
        chk(ext_gnt == 4'b0010, "R3", "first from ptr 0", int'(ext_gnt), 2);
        ext_req = 4'b1000; cyc();
        chk(ext_gnt == 4'b0000, "R6", "release when idle", int'(ext_gnt), 0);
        cyc();
        chk(ext_gnt == 4'b1000, "R3", "top index", int'(ext_gnt), 8);
        ext_req = 4'b0111; cyc(); cyc();
        chk(ext_gnt == 4'b0001, "R3", "wrap to 0", int'(ext_gnt), 1);

        // local priority and pointer retention
        tag = "R4";
        ext_req = 4'b0110; loc_req = 1'b1; cyc(); cyc();
        chk(loc_gnt == 1'b1 && ext_gnt == 0, "R2", "local wins", int'(loc_gnt), 1);
        loc_req = 1'b0; cyc(); cyc();
        chk(ext_gnt == 4'b0010, "R4", "resume after local", int'(ext_gnt), 2);

        // hold on busy
        tag = "R6";
        ext_req = 4'b0000; bus_busy = 1'b1; cycn(3);
        chk(ext_gnt == 4'b0010, "R6", "held by busy", int'(ext_gnt), 2);
        bus_busy = 1'b0; cyc();
        chk(ext_gnt == 4'b0000, "R6", "dropped", int'(ext_gnt), 0);

        // no grant while busy
        tag = "R5";
        bus_busy = 1'b1; ext_req = 4'b0100; cycn(3);
        chk(ext_gnt == 4'b0000, "R5", "no grant while busy", int'(ext_gnt), 0);
        bus_busy = 1'b0; cyc();
        chk(ext_gnt == 4'b0100, "R5", "grant once idle", int'(ext_gnt), 4);
        ext_req = '0; cyc();

        // random traffic against the model
        tag = "R2/R3/R5/R6/R7/R10";
        for (int i = 0; i < 3000; i++) begin
            ext_req     = N'($urandom);
            loc_req     = ($urandom % 8) == 0;
            bus_busy    = ($urandom % 4) == 0;
            xfer_strobe = ($urandom % 4) == 0;
            xfer_ack    = ($urandom % 2) == 0;
            mem_sel     = ($urandom % 2) == 0;
            fail_hold   = ($urandom % 4) == 0;
            cyc();
        end
        ext_req = '0; loc_req = 0; bus_busy = 0; xfer_strobe = 0;
        xfer_ack = 0; mem_sel = 0; fail_hold = 0;
        cycn(2);

        // timeout exact edge
        tag = "R8";
        xfer_strobe = 1'b1; cycn(LIM - 1);
        chk(bus_err == 1'b0, "R8", "no error one edge early", int'(bus_err), 0);
        cyc();
        chk(bus_err == 1'b1, "R8", "error at limit", int'(bus_err), 1);
        cycn(5);
        chk(bus_err == 1'b1, "R11", "error held with strobe", int'(bus_err), 1);
        xfer_strobe = 1'b0; cyc();
        chk(bus_err == 1'b0, "R11", "cleared by strobe low", int'(bus_err), 0);

        // acknowledge restarts the count
        tag = "R9";
        xfer_strobe = 1'b1; cycn(1000);
        xfer_ack = 1'b1; cyc(); xfer_ack = 1'b0;
        cycn(LIM - 1);
        chk(bus_err == 1'b0, "R9", "count restarted", int'(bus_err), 0);
        cyc();
        chk(bus_err == 1'b1, "R9", "limit after restart", int'(bus_err), 1);
        xfer_strobe = 1'b0; cyc();

        // refused access during fail hold
        tag = "R10";
        ext_req = 4'b0010; cyc();
        xfer_strobe = 1'b1; mem_sel = 1'b1; fail_hold = 1'b1; xfer_ack = 1'b1; cyc();
        chk(bus_err == 1'b1, "R10", "external refused", int'(bus_err), 1);
        xfer_strobe = 1'b0; cyc();
        fail_hold = 1'b0; xfer_strobe = 1'b1; cyc();
        chk(bus_err == 1'b0, "R10", "allowed after fail released", int'(bus_err), 0);
        xfer_strobe = 1'b0; ext_req = '0; cyc();
        loc_req = 1'b1; cyc();
        fail_hold = 1'b1; xfer_strobe = 1'b1; cyc();
        chk(loc_gnt == 1'b1 && bus_err == 1'b0, "R10", "local not refused",
            int'(bus_err), 0);
        xfer_strobe = 1'b0; loc_req = 1'b0; fail_hold = 1'b0; mem_sel = 1'b0;
        xfer_ack = 1'b0;
        cycn(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule